// File: doc/BRIEF.md
# Latched-Address Banked I/O Port

This block is an 8-bit peripheral port on a shared bus that carries addresses and data over the same eight wires in separate cycles. Two bank lines split the bus into a left and a right half, and each port instance belongs to one of them, chosen by a parameter. When its own bank line is high and the bus is in an address phase, the port compares the bus byte with its configured address and keeps the result in a selection latch. That latch then governs every data cycle on the same bank until the next address phase on that bank.

While selected, a data write copies the bus byte into an output register that drives the user-side output pins. A data read puts the user-side input byte on the bus output and raises the output enable. Because the selection is held, software can address a port once and then access it any number of times. A left-bank port and a right-bank port can both be selected at the same moment. Toggling the bank lines moves between them without another address phase.

Top module: `latched_io_port`

## Requirements
- R1: While reset is held and after it is released, `user_out` is 0x00, `bus_oe` is 0 and the port is not selected, so a read cycle on its bank does not enable the bus.
- R2: A cycle with the own bank line high and `cmd_sel`=1 whose `bus_in` equals `PORT_ADDR` selects the port from the next clock edge on.
- R3: A cycle with the own bank line high and `cmd_sel`=1 whose `bus_in` differs from `PORT_ADDR` deselects the port from the next clock edge on.
- R4: A cycle with the own bank line low changes neither the selection nor `user_out`, whatever `cmd_sel`, `cmd_wr` and `bus_in` carry.
- R5: A cycle with the own bank line high, `cmd_sel`=0, `cmd_wr`=1 and the port selected loads `bus_in` into `user_out` at that clock edge. `user_out` holds the value until the next such write.
- R6: A write cycle (own bank high, `cmd_sel`=0, `cmd_wr`=1) while the port is not selected leaves `user_out` unchanged.
- R7: In a cycle with the own bank line high, `cmd_sel`=0, `cmd_wr`=0 and the port selected, `bus_oe` is 1 and `bus_out` equals `user_in` in the same cycle. In every other cycle, `bus_oe` is 0 and `bus_out` is 0x00.
- R8: Data read and write cycles never change the selection, so any number of them may follow a single address phase.
- R9: `BANK_SIDE`=0 attaches the port to `bank_l` and `BANK_SIDE`=1 attaches it to `bank_r`. A left port and a right port can both be selected at once and can be accessed alternately without re-addressing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_l | input | 1 | Left bank line |
| bank_r | input | 1 | Right bank line |
| cmd_sel | input | 1 | 1 = address phase, 0 = data cycle |
| cmd_wr | input | 1 | In a data cycle: 1 = write, 0 = read |
| bus_in | input | 8 | Byte received from the shared bus |
| bus_out | output | 8 | Byte driven onto the bus on a read, else 0 |
| bus_oe | output | 1 | Bus output enable |
| user_in | input | 8 | User-side input byte |
| user_out | output | 8 | User-side output register |

## Verification
A left-bank port and a right-bank port share one bus in the bench. Addresses are sent first to the correct value and then to a near miss, which separates exact comparison from a latch that only ever sets. Long strings of reads and writes after a single address phase show that the selection persists. Interleaving traffic on the two banks, including writes and address phases aimed at the other side, shows whether one bank's activity leaks into the other port's state. A write sent while the port is deselected, followed by a fresh address and a read of the output pins, shows that unselected writes are dropped.

// File: rtl/lio_pkg.sv
package lio_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_ADDR  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_READ  = 2'd3
  } cyc_e;

  // Classify one bus cycle as seen from a single bank.
  function automatic cyc_e classify(input logic own_bank,
                                    input logic sel,
                                    input logic wr);
    cyc_e c;
    if (!own_bank)  c = CYC_IDLE;
    else if (sel)   c = CYC_ADDR;
    else if (wr)    c = CYC_WRITE;
    else            c = CYC_READ;
    return c;
  endfunction

endpackage

// File: rtl/lio_rst_sync.sv
module lio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lio_decode.sv
module lio_decode
  import lio_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] PORT_ADDR = '0,
  parameter int          BANK_SIDE = 0
) (
  input  logic          bank_l,
  input  logic          bank_r,
  input  logic          cmd_sel,
  input  logic          cmd_wr,
  input  logic [DW-1:0] bus_in,
  output cyc_e          cyc,
  output logic          addr_hit
);

  localparam int SIDE_IDX = (BANK_SIDE != 0) ? 1 : 0;

  logic [1:0] banks;
  logic       own_bank;

  assign banks    = {bank_r, bank_l};
  assign own_bank = banks[SIDE_IDX];

  always_comb begin
    cyc      = classify(own_bank, cmd_sel, cmd_wr);
    addr_hit = (bus_in == PORT_ADDR);
  end

endmodule

// File: rtl/lio_sel_latch.sv
module lio_sel_latch
  import lio_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cyc_e cyc,
  input  logic addr_hit,
  output logic sel_q
);

  logic sel_en;
  logic sel_d;

  always_comb begin
    sel_en = (cyc == CYC_ADDR);
    sel_d  = addr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (sel_en) sel_q <= sel_d;
  end

endmodule

// File: rtl/lio_out_reg.sv
module lio_out_reg
  import lio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cyc_e          cyc,
  input  logic          sel_q,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] out_q
);

  logic          load_en;
  logic [DW-1:0] out_d;

  always_comb begin
    load_en = (cyc == CYC_WRITE) && sel_q;
    out_d   = bus_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (load_en) out_q <= out_d;
  end

endmodule

// File: rtl/latched_io_port.sv
module latched_io_port
  import lio_pkg::*;
#(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] PORT_ADDR = 8'h35,
  parameter int            BANK_SIDE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_l,
  input  logic          bank_r,
  input  logic          cmd_sel,
  input  logic          cmd_wr,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] user_in,
  output logic [DW-1:0] user_out
);

  logic rst_sync_n;
  cyc_e cyc;
  logic addr_hit;
  logic sel_q;

  lio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lio_decode #(.DW(DW), .PORT_ADDR(PORT_ADDR), .BANK_SIDE(BANK_SIDE)) u_dec (
    .bank_l   (bank_l),
    .bank_r   (bank_r),
    .cmd_sel  (cmd_sel),
    .cmd_wr   (cmd_wr),
    .bus_in   (bus_in),
    .cyc      (cyc),
    .addr_hit (addr_hit)
  );

  lio_sel_latch u_sel (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cyc      (cyc),
    .addr_hit (addr_hit),
    .sel_q    (sel_q)
  );

  lio_out_reg #(.DW(DW)) u_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cyc    (cyc),
    .sel_q  (sel_q),
    .bus_in (bus_in),
    .out_q  (user_out)
  );

  // Read path: drive the user byte only while selected and reading.
  always_comb begin
    bus_oe  = (cyc == CYC_READ) && sel_q;
    bus_out = bus_oe ? user_in : '0;
  end

endmodule

// File: rtl/latched_io_port_chk.sv
module latched_io_port_chk #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] PORT_ADDR = 8'h35,
  parameter int            BANK_SIDE = 0
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          bank_l,
  input logic          bank_r,
  input logic          cmd_sel,
  input logic          cmd_wr,
  input logic [DW-1:0] bus_in,
  input logic [DW-1:0] bus_out,
  input logic          bus_oe,
  input logic [DW-1:0] user_in,
  input logic [DW-1:0] user_out,
  input logic          sel_q
);

  logic own;
  assign own = (BANK_SIDE != 0) ? bank_r : bank_l;

  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_sync_n |-> (user_out == '0 && !bus_oe));

  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own && cmd_sel && bus_in == PORT_ADDR) |=> sel_q);

  // R3
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own && cmd_sel && bus_in != PORT_ADDR) |=> !sel_q);

  // R4
  other_bank_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !own |=> ($stable(sel_q) && $stable(user_out)));

  // R5
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own && !cmd_sel && cmd_wr && sel_q) |=> (user_out == $past(bus_in)));

  // R6
  write_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own && !cmd_sel && cmd_wr && !sel_q) |=> $stable(user_out));

  // R7
  read_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_oe |-> (bus_out == user_in && own && !cmd_sel && !cmd_wr));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_oe |-> (bus_out == '0));

  // R8
  data_keep_sel_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (own && !cmd_sel) |=> $stable(sel_q));

endmodule

bind latched_io_port latched_io_port_chk #(
  .DW(DW), .PORT_ADDR(PORT_ADDR), .BANK_SIDE(BANK_SIDE)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bank_l     (bank_l),
  .bank_r     (bank_r),
  .cmd_sel    (cmd_sel),
  .cmd_wr     (cmd_wr),
  .bus_in     (bus_in),
  .bus_out    (bus_out),
  .bus_oe     (bus_oe),
  .user_in    (user_in),
  .user_out   (user_out),
  .sel_q      (sel_q)
);

// File: tb/sim_latched_io_port.sv
`timescale 1ns/1ps
module sim_latched_io_port;

  localparam logic [7:0] ADDR_L = 8'h35;
  localparam logic [7:0] ADDR_R = 8'hA2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_l = 1'b0, bank_r = 1'b0, cmd_sel = 1'b0, cmd_wr = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] uin0 = 8'h5A, uin1 = 8'hC3;
  logic [7:0] dout0, dout1, uout0, uout1;
  logic       oe0, oe1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected-item queues (scoreboard)
  logic        q_oe0[$], q_oe1[$];
  logic [7:0]  q_d0[$], q_d1[$], q_u0[$], q_u1[$];
  string       q_tag[$];

  // bench model state
  logic       m_sel0 = 1'b0, m_sel1 = 1'b0;
  logic [7:0] m_u0 = 8'h00, m_u1 = 8'h00;

  always #5 clk = ~clk;

  latched_io_port #(.PORT_ADDR(ADDR_L), .BANK_SIDE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .bank_l(bank_l), .bank_r(bank_r),
    .cmd_sel(cmd_sel), .cmd_wr(cmd_wr), .bus_in(bus_in),
    .bus_out(dout0), .bus_oe(oe0), .user_in(uin0), .user_out(uout0));

  latched_io_port #(.PORT_ADDR(ADDR_R), .BANK_SIDE(1)) u1 (
    .clk(clk), .rst_n(rst_n), .bank_l(bank_l), .bank_r(bank_r),
    .cmd_sel(cmd_sel), .cmd_wr(cmd_wr), .bus_in(bus_in),
    .bus_out(dout1), .bus_oe(oe1), .user_in(uin1), .user_out(uout1));

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Driver: one bus cycle, expectations from the requirements.
  task automatic cyc(input logic bl, input logic br, input logic s,
                     input logic w, input logic [7:0] d, input string tag);
    logic rd0, rd1;
    @(negedge clk);
    bank_l = bl; bank_r = br; cmd_sel = s; cmd_wr = w; bus_in = d;
    rd0 = bl && !s && !w && m_sel0;
    rd1 = br && !s && !w && m_sel1;
    q_oe0.push_back(rd0); q_d0.push_back(rd0 ? uin0 : 8'h00); q_u0.push_back(m_u0);
    q_oe1.push_back(rd1); q_d1.push_back(rd1 ? uin1 : 8'h00); q_u1.push_back(m_u1);
    q_tag.push_back(tag);
    if (bl && s) m_sel0 = (d == ADDR_L);
    else if (bl && w && m_sel0) m_u0 = d;
    if (br && s) m_sel1 = (d == ADDR_R);
    else if (br && w && m_sel1) m_u1 = d;
  endtask

  // Monitor: pops expected items, compares mid-low-phase.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q_tag.size() > 0) begin
        logic e_oe0, e_oe1;
        logic [7:0] e_d0, e_d1, e_u0, e_u1;
        string t;
        e_oe0 = q_oe0.pop_front(); e_d0 = q_d0.pop_front(); e_u0 = q_u0.pop_front();
        e_oe1 = q_oe1.pop_front(); e_d1 = q_d1.pop_front(); e_u1 = q_u1.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (oe0 !== e_oe0 || dout0 !== e_d0 || uout0 !== e_u0 ||
            oe1 !== e_oe1 || dout1 !== e_d1 || uout1 !== e_u1) begin
          fails++;
          $display("FAIL %s: got oe0=%b d0=%h u0=%h oe1=%b d1=%h u1=%h exp oe0=%b d0=%h u0=%h oe1=%b d1=%h u1=%h",
                   t, oe0, dout0, uout0, oe1, dout1, uout1,
                   e_oe0, e_d0, e_u0, e_oe1, e_d1, e_u1);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(10 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    // R1: reset state while reset held, with a read cycle presented
    bank_l = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (uout0 !== 8'h00 || oe0 !== 1'b0) begin
      fails++;
      $display("FAIL R1: got u0=%h oe0=%b exp u0=00 oe0=0", uout0, oe0);
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    cyc(1, 0, 0, 0, 8'h00, "R1 read before any address");
    cyc(1, 0, 1, 0, ADDR_L, "R2 address left");
    cyc(1, 0, 0, 0, 8'h00, "R2/R7 read after address");
    cyc(1, 0, 0, 1, 8'h81, "R5 write left");
    cyc(1, 0, 0, 0, 8'h00, "R5/R8 read holds output");
    @(negedge clk); uin0 = 8'h3C;
    cyc(1, 0, 0, 0, 8'h00, "R7 read follows user_in");
    cyc(1, 0, 0, 1, 8'h17, "R8 second write no re-address");
    cyc(0, 0, 0, 0, 8'h00, "R7 idle no bank");
    cyc(0, 1, 1, 0, ADDR_R, "R9 address right");
    cyc(0, 1, 0, 1, 8'h44, "R4 right write leaves left");
    cyc(0, 1, 1, 0, ADDR_L, "R4 right addr with left value");
    cyc(1, 0, 0, 0, 8'h00, "R9 left still selected");
    cyc(0, 1, 1, 0, ADDR_R, "R9 reselect right");
    cyc(0, 1, 0, 0, 8'h00, "R9 right read");
    cyc(1, 0, 0, 0, 8'h00, "R9 alternate left read");
    cyc(1, 0, 1, 0, 8'h34, "R3 near-miss address left");
    cyc(1, 0, 0, 0, 8'h00, "R3 read deselected");
    cyc(1, 0, 0, 1, 8'hFF, "R6 write while deselected");
    cyc(1, 0, 1, 0, ADDR_L, "R6 re-address left");
    cyc(1, 0, 0, 0, 8'h00, "R6 output kept 17");
    cyc(0, 1, 0, 0, 8'h00, "R9 right still active");
    cyc(1, 1, 0, 1, 8'h99, "R9 both banks write");
    cyc(1, 1, 0, 0, 8'h00, "R9 both banks read");
    cyc(0, 0, 1, 1, 8'h00, "R4 no bank address");
    cyc(1, 0, 0, 0, 8'h00, "R4 left survives");
    @(negedge clk);
    while (q_tag.size() > 0) @(negedge clk);
    #5;
    summary();
  end

endmodule